// File: doc/BRIEF.md
# Three-Wire Tuner Control Word Receiver

This block takes the serial control stream of a tuner synthesizer: an enable line framing each transfer, a serial clock and a data line, all sampled by the chip's system clock. While enable is high, every rising edge of the serial clock shifts one data bit into a holding register, first bit first. When enable drops, the number of bits received decides both the layout of the word and the reference divider ratio that the frame implies.

Three lengths are recognised: 18 and 19 bits (band/port bits plus the divider word, with the reference ratio fixed by the length) and 27 bits (which also carries the ratio select, the charge-pump current select, test bits and a drive-off bit). A transfer of any other length is dropped without effect. A legal word updates every output in the same cycle and raises a one-cycle commit strobe.

Top module: `tw_word_receiver`

## Requirements
- R1: A bit is taken only on a system clock edge where `sclk_i` is sampled high, was low at the previous edge, and `en_i` is high; serial clock rises while `en_i` is low change nothing, and the bit count restarts from zero on each new high period of `en_i`.
- R2: At the first system clock edge where `en_i` is sampled low after being high, a legal word updates all outputs together and `commit_o` is high for exactly that one cycle.
- R3: A transfer whose bit count is not 18, 19 or 27 (including zero bits and any count above 27, however long) leaves every output unchanged and gives no strobe.
- R4: In every legal word the first four bits received drive `port_o`, the first bit landing in `port_o[3]` and the fourth in `port_o[0]`.
- R5: An 18-bit word loads its remaining 14 bits into `div_o[13:0]` (first bit most significant), clears `div_o[14]`, and sets `ref_sel_o` to code 0 (ratio 512).
- R6: A 19-bit word loads its remaining 15 bits into `div_o[14:0]` (first bit most significant) and sets `ref_sel_o` to code 2 (ratio 1024).
- R7: A 27-bit word carries, in order after the port bits: 15 divider bits to `div_o`, then a current-select bit to `cp_hi_o`, three test bits to `tmode_o[2]`, `tmode_o[1]`, `tmode_o[0]`, two ratio bits A then B, a bit to `drv_off_o`, and one spare bit that is ignored.
- R8: For a 27-bit word `ref_sel_o` follows the ratio bits {A,B}: 11 gives code 0 (512), 00 gives code 1 (640), 01 or 10 give code 2 (1024); code 3 never appears.
- R9: 18- and 19-bit words leave `cp_hi_o`, `tmode_o` and `drv_off_o` at their previous values.
- R10: Synchronous active-high `rst` sets all outputs to zero (`ref_sel_o` code 0) and `commit_o` low.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Transfer enable, high while a word is sent |
| sclk_i | input | 1 | Serial bit clock, data taken on its rise |
| dat_i | input | 1 | Serial data |
| port_o | output | 4 | Band and port selects |
| div_o | output | 15 | Programmable divider ratio |
| ref_sel_o | output | 2 | Reference ratio code: 0=512, 1=640, 2=1024 |
| cp_hi_o | output | 1 | Charge-pump high current select |
| tmode_o | output | 3 | Test mode bits |
| drv_off_o | output | 1 | Tuning drive disable |
| commit_o | output | 1 | One-cycle strobe when a legal word is applied |

## Verification
Each serial bit takes effect at the system clock edge that first sees its clock high, and a word's outputs and strobe appear one register after the edge that first sees enable low. The bench drops enable at a falling clock edge, so the result is due right after the following rising edge; it samples every output at the next falling edge, then one cycle later confirms that the strobe has cleared. Rejected lengths are checked at that same point, showing that no output moved and that no strobe appeared.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int PORT_W = 4;
    localparam int DIV_W  = 15;
    localparam int TEST_W = 3;
    localparam int LEN_A  = 18;
    localparam int LEN_B  = 19;
    localparam int LEN_C  = 27;
    localparam int CNT_W  = $clog2(LEN_C + 2);

    typedef enum logic [1:0] {
        REF_512  = 2'd0,
        REF_640  = 2'd1,
        REF_1024 = 2'd2
    } ref_e;

    typedef enum logic [1:0] {
        FMT_NONE,
        FMT_A,
        FMT_B,
        FMT_C
    } fmt_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [DIV_W-1:0]  div;
        ref_e              rsel;
        logic              cp;
        logic [TEST_W-1:0] tmode;
        logic              drv_off;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        port:    '0,
        div:     '0,
        rsel:    REF_512,
        cp:      1'b0,
        tmode:   '0,
        drv_off: 1'b0
    };

    function automatic ref_e ratio_from_bits(input logic a, input logic b);
        case ({a, b})
            2'b11:   return REF_512;
            2'b00:   return REF_640;
            default: return REF_1024;
        endcase
    endfunction

    function automatic fmt_e classify(input logic [CNT_W-1:0] n);
        if (n == CNT_W'(LEN_A))      return FMT_A;
        else if (n == CNT_W'(LEN_B)) return FMT_B;
        else if (n == CNT_W'(LEN_C)) return FMT_C;
        else                         return FMT_NONE;
    endfunction

endpackage

// File: rtl/tw_shifter.sv
module tw_shifter
    import tw_pkg::*;
#(
    parameter int LEN_MAX = LEN_C,
    parameter int CW      = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic               sclk_i,
    input  logic               dat_i,
    output logic [LEN_MAX-1:0] sr_o,
    output logic [CW-1:0]      cnt_o,
    output logic               fall_o
);

    localparam logic [CW-1:0] CNT_SAT = CW'(LEN_MAX + 1);

    logic en_q;
    logic sclk_q;
    logic take;

    // a bit is taken on the first system edge that sees the serial clock high
    assign take   = en_i && sclk_i && !sclk_q;
    assign fall_o = en_q && !en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            sclk_q <= 1'b0;
            sr_o   <= '0;
            cnt_o  <= '0;
        end else begin
            en_q   <= en_i;
            sclk_q <= sclk_i;
            if (!en_i) begin
                cnt_o <= '0;
            end else if (take) begin
                sr_o <= {sr_o[LEN_MAX-2:0], dat_i};
                // saturate so that overlong words can never alias a legal count
                if (cnt_o != CNT_SAT) begin
                    cnt_o <= cnt_o + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tw_decoder.sv
module tw_decoder
    import tw_pkg::*;
(
    input  logic [LEN_C-1:0] sr_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  cfg_t             cur_i,
    output cfg_t             nxt_o,
    output logic             legal_o
);

    localparam int A_DIV  = LEN_A - PORT_W;
    localparam int C_DTOP = LEN_C - PORT_W - 1;
    localparam int C_CTL  = C_DTOP - DIV_W;

    always_comb begin
        nxt_o   = cur_i;
        legal_o = 1'b0;
        case (classify(cnt_i))
            FMT_A: begin
                legal_o    = 1'b1;
                nxt_o.port = sr_i[LEN_A-1 -: PORT_W];
                nxt_o.div  = DIV_W'(sr_i[A_DIV-1:0]);
                nxt_o.rsel = REF_512;
            end
            FMT_B: begin
                legal_o    = 1'b1;
                nxt_o.port = sr_i[LEN_B-1 -: PORT_W];
                nxt_o.div  = sr_i[DIV_W-1:0];
                nxt_o.rsel = REF_1024;
            end
            FMT_C: begin
                legal_o       = 1'b1;
                nxt_o.port    = sr_i[LEN_C-1 -: PORT_W];
                nxt_o.div     = sr_i[C_DTOP -: DIV_W];
                nxt_o.cp      = sr_i[C_CTL];
                nxt_o.tmode   = sr_i[C_CTL-1 -: TEST_W];
                nxt_o.rsel    = ratio_from_bits(sr_i[C_CTL-TEST_W-1], sr_i[C_CTL-TEST_W-2]);
                nxt_o.drv_off = sr_i[C_CTL-TEST_W-3];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tw_word_receiver.sv
module tw_word_receiver
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              sclk_i,
    input  logic              dat_i,
    output logic [PORT_W-1:0] port_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [1:0]        ref_sel_o,
    output logic              cp_hi_o,
    output logic [TEST_W-1:0] tmode_o,
    output logic              drv_off_o,
    output logic              commit_o
);

    logic [LEN_C-1:0] sr;
    logic [CNT_W-1:0] cnt;
    logic             fall;
    logic             legal;
    cfg_t             cfg_q;
    cfg_t             cfg_nxt;

    tw_shifter #(
        .LEN_MAX (LEN_C),
        .CW      (CNT_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .sclk_i (sclk_i),
        .dat_i  (dat_i),
        .sr_o   (sr),
        .cnt_o  (cnt),
        .fall_o (fall)
    );

    tw_decoder u_dec (
        .sr_i    (sr),
        .cnt_i   (cnt),
        .cur_i   (cfg_q),
        .nxt_o   (cfg_nxt),
        .legal_o (legal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CFG_RST;
            commit_o <= 1'b0;
        end else begin
            commit_o <= fall && legal;
            if (fall && legal) begin
                cfg_q <= cfg_nxt;
            end
        end
    end

    assign port_o    = cfg_q.port;
    assign div_o     = cfg_q.div;
    assign ref_sel_o = cfg_q.rsel;
    assign cp_hi_o   = cfg_q.cp;
    assign tmode_o   = cfg_q.tmode;
    assign drv_off_o = cfg_q.drv_off;

endmodule

// File: rtl/tw_word_receiver_chk.sv
module tw_word_receiver_chk
    import tw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic [PORT_W-1:0] port_o,
    input logic [DIV_W-1:0]  div_o,
    input logic [1:0]        ref_sel_o,
    input logic              cp_hi_o,
    input logic [TEST_W-1:0] tmode_o,
    input logic              drv_off_o,
    input logic              commit_o
);

    // R3 / R2: outputs move only in a commit cycle
    a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !commit_o |-> ($stable(port_o) && $stable(div_o) && $stable(ref_sel_o)
                       && $stable(cp_hi_o) && $stable(tmode_o) && $stable(drv_off_o)));

    // R2: strobe lasts a single cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o);

    // R2: strobe only follows a high-to-low enable transition
    a_r2_after_enable_fall: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> (!$past(en_i) && $past(en_i, 2)));

    // R8: the unused ratio code never appears
    a_r8_ratio_code: assert property (@(posedge clk) disable iff (rst)
        ref_sel_o != 2'd3);

endmodule

bind tw_word_receiver tw_word_receiver_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .port_o    (port_o),
    .div_o     (div_o),
    .ref_sel_o (ref_sel_o),
    .cp_hi_o   (cp_hi_o),
    .tmode_o   (tmode_o),
    .drv_off_o (drv_off_o),
    .commit_o  (commit_o)
);

// File: tb/tw_word_receiver_test.sv
module tw_word_receiver_test;

    logic        clk  = 1'b0;
    logic        rst  = 1'b1;
    logic        en   = 1'b0;
    logic        sclk = 1'b0;
    logic        dat  = 1'b0;
    logic [3:0]  port;
    logic [14:0] div;
    logic [1:0]  rsel;
    logic        cp;
    logic [2:0]  tm;
    logic        off;
    logic        commit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0]  e_port = '0;
    logic [14:0] e_div  = '0;
    logic [1:0]  e_ref  = '0;
    logic        e_cp   = 1'b0;
    logic [2:0]  e_tm   = '0;
    logic        e_off  = 1'b0;

    always #5 clk = ~clk;

    tw_word_receiver uut (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en),
        .sclk_i    (sclk),
        .dat_i     (dat),
        .port_o    (port),
        .div_o     (div),
        .ref_sel_o (rsel),
        .cp_hi_o   (cp),
        .tmode_o   (tm),
        .drv_off_o (off),
        .commit_o  (commit)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic stb);
        chk(req, "commit", 32'(commit), 32'(stb));
        chk(req, "port",   32'(port),   32'(e_port));
        chk(req, "div",    32'(div),    32'(e_div));
        chk(req, "ref",    32'(rsel),   32'(e_ref));
        chk(req, "cp",     32'(cp),     32'(e_cp));
        chk(req, "tmode",  32'(tm),     32'(e_tm));
        chk(req, "drvoff", 32'(off),    32'(e_off));
    endtask

    function automatic logic [1:0] ratio_code(input logic [1:0] ab);
        if (ab == 2'b11)      return 2'd0;
        else if (ab == 2'b00) return 2'd1;
        else                  return 2'd2;
    endfunction

    function automatic bit is_legal(input int len);
        return (len == 18) || (len == 19) || (len == 27);
    endfunction

    task automatic model(input logic [63:0] w, input int len);
        if (len == 18) begin
            e_port = w[17:14];
            e_div  = {1'b0, w[13:0]};
            e_ref  = 2'd0;
        end else if (len == 19) begin
            e_port = w[18:15];
            e_div  = w[14:0];
            e_ref  = 2'd2;
        end else if (len == 27) begin
            e_port = w[26:23];
            e_div  = w[22:8];
            e_cp   = w[7];
            e_tm   = w[6:4];
            e_ref  = ratio_code(w[3:2]);
            e_off  = w[1];
        end
    endtask

    task automatic send(input logic [63:0] w, input int len, input string req);
        @(negedge clk) en = 1'b1;
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk) dat = w[i];
            @(negedge clk) sclk = 1'b1;
            @(negedge clk) sclk = 1'b0;
        end
        @(negedge clk) en = 1'b0;
        if (is_legal(len)) model(w, len);
        @(negedge clk) chk_all(req, is_legal(len));
        @(negedge clk) chk(req, "strobe clears", 32'(commit), 32'd0);
    endtask

    function automatic string tag_for(input int len);
        if (len == 18)      return "R5";
        else if (len == 19) return "R6";
        else if (len == 27) return "R7";
        else                return "R3";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lens[8] = '{17, 18, 19, 20, 26, 27, 28, 50};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R10", 1'b0);

        // R4 / R5: port order and short word
        send(64'h2_AAAA, 18, "R4");
        send(64'h1_5555, 18, "R5");
        // R6
        send(64'h5_7FFF, 19, "R6");
        send(64'h2_4001, 19, "R6");
        // R7 and R8: every ratio-bit combination
        for (int ab = 0; ab < 4; ab++) begin
            send({37'd0, 4'hA, 15'h4B2D, 1'b1, 3'b101, 2'(ab), 1'b1, 1'b1}, 27, "R8");
        end
        send({37'd0, 4'h3, 15'h1234, 1'b0, 3'b010, 2'b01, 1'b0, 1'b1}, 27, "R7");
        send({37'd0, 4'hC, 15'h7ACE, 1'b1, 3'b110, 2'b11, 1'b1, 1'b0}, 27, "R7");
        // R9: short words after a long word keep the control fields
        send(64'h3_0F0F, 18, "R9");
        send(64'h6_1357, 19, "R9");

        // R3: illegal lengths including empty and overlong
        send(64'h0, 0, "R3");
        send(64'h1_FFFF, 17, "R3");
        send(64'hF_FFFF, 20, "R3");
        send(64'h3FF_FFFF, 26, "R3");
        send(64'hFFF_FFFF, 28, "R3");
        send(64'h3_FFFF_FFFF_FFFF, 50, "R3");
        send(64'h7_FFFF_FFFF_FFFF, 51, "R3");

        // R1: serial clocks while enable is low are ignored
        @(negedge clk) dat = 1'b1;
        repeat (5) begin
            @(negedge clk) sclk = 1'b1;
            @(negedge clk) sclk = 1'b0;
        end
        @(negedge clk);
        chk_all("R1", 1'b0);
        send(64'h2_1234, 18, "R1");

        // R2: commit lands exactly one edge after enable falls
        @(negedge clk) en = 1'b1;
        for (int i = 18; i >= 0; i--) begin
            @(negedge clk) dat = (i % 3) == 0;
            @(negedge clk) sclk = 1'b1;
            @(negedge clk) sclk = 1'b0;
        end
        @(negedge clk);
        chk("R2", "no strobe while enabled", 32'(commit), 32'd0);
        en = 1'b0;
        model(64'h4_9249, 19);
        @(negedge clk) chk_all("R2", 1'b1);
        @(negedge clk) chk("R2", "strobe clears", 32'(commit), 32'd0);

        // mixed random words
        for (int n = 0; n < 60; n++) begin
            int len;
            logic [63:0] w;
            len = lens[$urandom % 8];
            w   = {$urandom, $urandom};
            send(w, len, tag_for(len));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule